// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

This block is an 8-bit up-counter that advances on a divided version of a tick-enable input. A prescaler passes one of every 1, 4 or 16 tick-enable pulses to the counter. Each time an advance finds the counter equal to a programmable period value, the counter goes back to zero instead of incrementing. That event is a match.

Each match produces a one-cycle pulse on a dedicated output, so that a neighbouring serial block can use it as a bit-rate clock. Matches also pass through a postscaler that divides them by 1 to 16. The postscaler sets a sticky interrupt flag, and software clears the flag.

Software reaches the counter, the period, a control register and the flag through a small synchronous register port. Read data is registered. Writing the counter or the control register restarts both scalers.

Top module: `match_timer`

## Requirements
- R1: The counter register (address 0) is 8 bits, readable and writable, and resets to 8'h00.
- R2: The period register (address 1) is 8 bits, readable and writable, and resets to 8'hFF.
- R3: On each prescaled tick the counter loads 8'h00 if it equals the period and otherwise adds one, rolling over from 8'hFF to 8'h00.
- R4: Control bits [1:0] set the prescale ratio. The value 00 divides by 1, 01 divides by 4, and 10 or 11 divide by 16 pulses of tick_en.
- R5: Control bits [6:3] hold a value N. The flag is set on every (N+1)-th match, counted from the last time the postscaler was cleared.
- R6: The control register (address 2) resets to 8'h00. Bit 2 is the run enable, and bit 7 always reads 0.
- R7: While the run enable is 0, the counter, prescaler and postscaler all keep their values.
- R8: A write to the counter or to the control register clears the prescaler and the postscaler. A control write leaves the counter unchanged.
- R9: match_pulse is high for exactly the cycle after the clock edge at which a match returned the counter to 8'h00.
- R10: The flag (address 3, bit 0) stays set until software writes a 0 to bit 0. Writing a 1 has no effect. When a postscaled event and a clearing write fall in the same cycle, the flag is set.
- R11: A write to the counter takes priority over a tick in the same cycle. Counting continues from the written value on the next prescaled tick.
- R12: reg_rdata returns, one cycle after the address is presented, the register selected by reg_addr. Unused bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count-enable pulse that feeds the prescaler |
| reg_addr | input | 2 | Register select: 0 counter, 1 period, 2 control, 3 flag |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| match_pulse | output | 1 | One-cycle pulse per match, taken before the postscaler |
| irq_flag | output | 1 | Sticky postscaled interrupt flag |

## Verification
Two things can fall in the same cycle: a postscaled match setting the flag and a software write clearing it. The bench provokes this directly. It sets the period to zero with prescale and postscale both at 1:1, so that every tick is a match, and then writes 0 to the flag on every cycle. Each cycle it expects the flag to remain 1. The random phase produces further collisions of this kind, and also counter writes that coincide with a prescaled tick. The bench's reference model judges each of these cycles.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam logic [1:0] A_COUNT  = 2'd0;
  localparam logic [1:0] A_PERIOD = 2'd1;
  localparam logic [1:0] A_CTRL   = 2'd2;
  localparam logic [1:0] A_FLAG   = 2'd3;

  localparam int CTRL_RUN_BIT = 2;
  localparam int CTRL_PS_LSB  = 3;

  // terminal value of the prescaler for a select code
  function automatic logic [3:0] pre_limit(input logic [1:0] sel);
    case (sel)
      2'b00:   pre_limit = 4'd0;
      2'b01:   pre_limit = 4'd3;
      default: pre_limit = 4'd15;
    endcase
  endfunction
endpackage

// File: rtl/mt_prescale.sv
module mt_prescale #(
  parameter int PRE_W = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       tick_o
);
  import mt_pkg::*;

  logic [PRE_W-1:0] pcnt_q;
  logic [PRE_W-1:0] lim;
  logic             at_end;

  assign lim    = PRE_W'(pre_limit(sel));
  assign at_end = (pcnt_q == lim);
  assign tick_o = run && !clr && at_end;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pcnt_q <= '0;
    end else if (run) begin
      pcnt_q <= at_end ? '0 : pcnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mt_count.sv
module mt_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             match_q
);
  logic [CNT_W-1:0] cnt_q;

  assign wrap_o = step && !load && (cnt_q == period);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      match_q <= 1'b0;
    end else begin
      match_q <= wrap_o;
      if (load) begin
        cnt_q <= load_val;
      end else if (step) begin
        cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mt_postscale.sv
module mt_postscale #(
  parameter int POST_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              evt,
  input  logic [POST_W-1:0] ratio,
  output logic              hit_o
);
  logic [POST_W-1:0] ecnt_q;

  assign hit_o = evt && !clr && (ecnt_q == ratio);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ecnt_q <= '0;
    end else if (evt) begin
      ecnt_q <= (ecnt_q == ratio) ? '0 : ecnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/match_timer.sv
module match_timer #(
  parameter int CNT_W  = 8,
  parameter int POST_W = 4,
  parameter int PRE_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic [1:0]       reg_addr,
  input  logic             reg_we,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             match_pulse,
  output logic             irq_flag
);
  import mt_pkg::*;

  localparam int PS_MSB = CTRL_PS_LSB + POST_W - 1;
  localparam logic [CNT_W-1:0] CTRL_MASK = CNT_W'((1 << (PS_MSB + 1)) - 1);

  logic [CNT_W-1:0] ctrl_q;
  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;

  logic wr_cnt, wr_per, wr_ctrl, wr_flag;
  logic scl_clr, run_en, pre_tick, wrap, post_hit;

  assign wr_cnt  = reg_we && (reg_addr == A_COUNT);
  assign wr_per  = reg_we && (reg_addr == A_PERIOD);
  assign wr_ctrl = reg_we && (reg_addr == A_CTRL);
  assign wr_flag = reg_we && (reg_addr == A_FLAG);
  assign scl_clr = wr_cnt || wr_ctrl;
  assign run_en  = ctrl_q[CTRL_RUN_BIT];

  mt_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .clr    (scl_clr),
    .run    (run_en && tick_en),
    .sel    (ctrl_q[1:0]),
    .tick_o (pre_tick)
  );

  mt_count #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (wr_cnt),
    .load_val (reg_wdata),
    .step     (pre_tick),
    .period   (period_q),
    .cnt_o    (cnt_q),
    .wrap_o   (wrap),
    .match_q  (match_pulse)
  );

  mt_postscale #(.POST_W(POST_W)) u_post (
    .clk   (clk),
    .rst   (rst),
    .clr   (scl_clr),
    .evt   (wrap),
    .ratio (ctrl_q[PS_MSB:CTRL_PS_LSB]),
    .hit_o (post_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      period_q <= '1;
      flag_q   <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata & CTRL_MASK;
      if (wr_per)  period_q <= reg_wdata;
      if (post_hit) begin
        flag_q <= 1'b1;
      end else if (wr_flag && !reg_wdata[0]) begin
        flag_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        A_COUNT:  reg_rdata <= cnt_q;
        A_PERIOD: reg_rdata <= period_q;
        A_CTRL:   reg_rdata <= ctrl_q;
        default:  reg_rdata <= {{(CNT_W-1){1'b0}}, flag_q};
      endcase
    end
  end

  assign irq_flag = flag_q;
endmodule

// File: rtl/mt_checker.sv
module mt_checker #(
  parameter int CNT_W = 8,
  parameter int PRE_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             match_pulse,
  input logic             irq_flag,
  input logic             reg_we,
  input logic [1:0]       reg_addr,
  input logic [CNT_W-1:0] reg_wdata,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] ctrl_q,
  input logic [PRE_W-1:0] pre_cnt
);
  import mt_pkg::*;

  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  assert_match_at_zero_R9: assert property (@(posedge clk) disable iff (rst)
    match_pulse |-> (cnt_q == '0));

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(irq_flag) &&
     !$past(reg_we && reg_addr == A_FLAG && !reg_wdata[0])) |-> irq_flag);

  assert_hold_when_off_R7: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(ctrl_q[CTRL_RUN_BIT]) && !$past(reg_we))
      |-> ($stable(cnt_q) && $stable(pre_cnt)));

  assert_ctrl_keeps_count_R8: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(reg_we && reg_addr == A_CTRL)) |-> $stable(cnt_q));

  assert_ctrl_msb_zero_R6: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[CNT_W-1] == 1'b0);

  assert_pre_in_range_R4: assert property (@(posedge clk) disable iff (rst)
    pre_cnt <= PRE_W'(pre_limit(ctrl_q[1:0])));
endmodule

bind match_timer mt_checker #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_mt_checker (
  .clk         (clk),
  .rst         (rst),
  .match_pulse (match_pulse),
  .irq_flag    (irq_flag),
  .reg_we      (reg_we),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .cnt_q       (cnt_q),
  .ctrl_q      (ctrl_q),
  .pre_cnt     (u_pre.pcnt_q)
);

// File: tb/test_match_timer.sv
`timescale 1ns/1ps
module test_match_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       match_pulse, irq_flag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference state
  logic [7:0] m_tmr, m_per, m_ctrl, m_rd;
  logic [3:0] m_pc, m_po;
  logic       m_flag, m_match;
  logic [1:0] last_addr;

  always #5 clk = ~clk;

  match_timer i_match_timer (
    .clk(clk), .rst(rst), .tick_en(tick_en), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .match_pulse(match_pulse), .irq_flag(irq_flag)
  );

  function automatic logic [3:0] lim_of(input logic [1:0] s);
    return (s == 2'b00) ? 4'd0 : (s == 2'b01) ? 4'd3 : 4'd15;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic model_reset();
    m_tmr = 8'h00; m_per = 8'hFF; m_ctrl = 8'h00; m_rd = 8'h00;
    m_pc = 4'd0; m_po = 4'd0; m_flag = 1'b0; m_match = 1'b0;
  endtask

  task automatic model_edge();
    logic clr, pt, hit, en;
    logic [3:0] lim;
    case (reg_addr)
      2'd0: m_rd = m_tmr;
      2'd1: m_rd = m_per;
      2'd2: m_rd = m_ctrl;
      default: m_rd = {7'd0, m_flag};
    endcase
    en  = m_ctrl[2];
    lim = lim_of(m_ctrl[1:0]);
    clr = reg_we && (reg_addr == 2'd0 || reg_addr == 2'd2);
    pt  = en && tick_en && !clr && (m_pc == lim);
    if (clr) m_pc = 4'd0;
    else if (en && tick_en) m_pc = (m_pc == lim) ? 4'd0 : m_pc + 4'd1;
    m_match = pt && (m_tmr == m_per);
    hit = 1'b0;
    if (clr) m_po = 4'd0;
    else if (m_match) begin
      if (m_po == m_ctrl[6:3]) begin m_po = 4'd0; hit = 1'b1; end
      else m_po = m_po + 4'd1;
    end
    if (reg_we && reg_addr == 2'd0) m_tmr = reg_wdata;
    else if (pt) m_tmr = m_match ? 8'h00 : m_tmr + 8'd1;
    if (hit) m_flag = 1'b1;
    else if (reg_we && reg_addr == 2'd3 && !reg_wdata[0]) m_flag = 1'b0;
    if (reg_we && reg_addr == 2'd1) m_per = reg_wdata;
    if (reg_we && reg_addr == 2'd2) m_ctrl = {1'b0, reg_wdata[6:0]};
  endtask

  task automatic step(input logic t, input logic we, input logic [1:0] a, input logic [7:0] d);
    tick_en = t; reg_we = we; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    model_edge();
    last_addr = a;
    @(negedge clk);
    chk(match_pulse == m_match, "R9 match_pulse", match_pulse, m_match);
    chk(irq_flag == m_flag, "R5/R10 irq_flag", irq_flag, m_flag);
    case (last_addr)
      2'd0: chk(reg_rdata == m_rd, "R1/R3 counter read", reg_rdata, m_rd);
      2'd1: chk(reg_rdata == m_rd, "R2 period read", reg_rdata, m_rd);
      2'd2: chk(reg_rdata == m_rd, "R6 control read", reg_rdata, m_rd);
      default: chk(reg_rdata == m_rd, "R12 flag read", reg_rdata, m_rd);
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(match_pulse == 1'b0 && irq_flag == 1'b0, "R9/R10 reset outputs", {match_pulse, irq_flag}, 0);

    // reset values through the register port (R12 latency)
    step(0, 0, 2'd0, 8'h00); chk(reg_rdata == 8'h00, "R1 reset counter", reg_rdata, 8'h00);
    step(0, 0, 2'd1, 8'h00); chk(reg_rdata == 8'hFF, "R2 reset period", reg_rdata, 8'hFF);
    step(0, 0, 2'd2, 8'h00); chk(reg_rdata == 8'h00, "R6 reset control", reg_rdata, 8'h00);
    step(0, 0, 2'd3, 8'h00); chk(reg_rdata == 8'h00, "R10 reset flag", reg_rdata, 8'h00);

    // R6: bit 7 ignored on write
    step(0, 1, 2'd2, 8'h80); step(0, 0, 2'd2, 8'h00);
    chk(reg_rdata == 8'h00, "R6 ctrl bit7 reads 0", reg_rdata, 8'h00);

    // R4: divide by 16 (select 10), 32 ticks -> counter 2
    step(0, 1, 2'd2, 8'h06);
    step(0, 1, 2'd0, 8'h00);
    for (int i = 0; i < 32; i++) step(1, 0, 2'd0, 8'h00);
    step(0, 0, 2'd0, 8'h00);
    chk(reg_rdata == 8'h02, "R4 prescale 1:16", reg_rdata, 8'h02);
    // divide by 4, 12 ticks -> counter 3
    step(0, 1, 2'd2, 8'h05);
    step(0, 1, 2'd0, 8'h00);
    for (int i = 0; i < 12; i++) step(1, 0, 2'd0, 8'h00);
    step(0, 0, 2'd0, 8'h00);
    chk(reg_rdata == 8'h03, "R4 prescale 1:4", reg_rdata, 8'h03);

    // R3: rollover past FF when above period
    step(0, 1, 2'd1, 8'h10);
    step(0, 1, 2'd2, 8'h04);
    step(0, 1, 2'd0, 8'hFF);
    step(1, 0, 2'd0, 8'h00);
    step(0, 0, 2'd0, 8'h00);
    chk(reg_rdata == 8'h00 && match_pulse == 1'b0, "R3 rollover no match", reg_rdata, 8'h00);

    // R5: period 0, 1:1, postscale N=2 -> flag on third match
    step(0, 1, 2'd1, 8'h00);
    step(0, 1, 2'd3, 8'h00);
    step(0, 1, 2'd2, 8'h14);
    step(1, 0, 2'd3, 8'h00); step(1, 0, 2'd3, 8'h00);
    chk(irq_flag == 1'b0, "R5 flag not yet", irq_flag, 0);
    step(1, 0, 2'd3, 8'h00);
    chk(irq_flag == 1'b1, "R5 flag on 3rd match", irq_flag, 1);

    // R10: set and clear in the same cycle, set wins
    step(0, 1, 2'd2, 8'h04);
    for (int i = 0; i < 6; i++) begin
      step(1, 1, 2'd3, 8'h00);
      chk(irq_flag == 1'b1, "R10 set beats clear", irq_flag, 1);
    end
    step(0, 1, 2'd3, 8'h00);
    chk(irq_flag == 1'b0, "R10 clear by write 0", irq_flag, 0);
    step(0, 1, 2'd3, 8'h01);
    chk(irq_flag == 1'b0, "R10 write 1 no effect", irq_flag, 0);

    // R7/R8: ctrl write keeps counter, disabled holds
    step(0, 1, 2'd1, 8'hF0);
    step(0, 1, 2'd0, 8'h55);
    step(0, 1, 2'd2, 8'h00);
    for (int i = 0; i < 10; i++) step(1, 0, 2'd0, 8'h00);
    step(0, 0, 2'd0, 8'h00);
    chk(reg_rdata == 8'h55, "R7/R8 hold while off", reg_rdata, 8'h55);

    // R11: counter write with a tick in the same cycle
    step(0, 1, 2'd2, 8'h04);
    step(1, 1, 2'd0, 8'h20);
    step(0, 0, 2'd0, 8'h00);
    chk(reg_rdata == 8'h20, "R11 write beats tick", reg_rdata, 8'h20);
    step(1, 0, 2'd0, 8'h00); step(0, 0, 2'd0, 8'h00);
    chk(reg_rdata == 8'h21, "R11 resumes counting", reg_rdata, 8'h21);

    // constrained random traffic checked against the reference model
    for (int i = 0; i < 20000; i++) begin
      int op;
      logic t;
      op = $urandom_range(0, 31);
      t  = ($urandom_range(0, 3) != 0);
      case (op)
        0: step(t, 1, 2'd0, 8'($urandom_range(0, 255)));
        1: step(t, 1, 2'd1, ($urandom_range(0, 7) == 0) ? 8'($urandom_range(0, 255))
                                                         : 8'($urandom_range(0, 7)));
        2: step(t, 1, 2'd2, 8'($urandom_range(0, 255)) | (($urandom_range(0, 4) != 0) ? 8'h04 : 8'h00));
        3: step(t, 1, 2'd3, 8'($urandom_range(0, 1)));
        default: step(t, 0, 2'($urandom_range(0, 3)), 8'($urandom_range(0, 255)));
      endcase
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule